// File: doc/BRIEF.md
# Integer Execute Unit with Instruction Decode

This block is the combinational execute stage of a 32-bit RISC integer pipeline. From one instruction word it takes the opcode, the function code, the shift-amount field, the 16-bit immediate and the two destination index fields. It also takes the two source register values. It decodes the operation and forms the second operand from either the register or the extended immediate. It then computes the result and states whether the destination register may be written.

The unit covers add and subtract, the bitwise operations, signed and unsigned set-less-than, and the three shifts, by a constant or by a register amount. It also covers the immediate forms of these and the load-upper-immediate. The trapping add and subtract flag signed overflow and block the write. Their unsigned-named twins compute the same value without a flag. Any encoding outside the supported map raises an illegal-instruction flag and writes nothing.

Top module: `alu_exec`

## Requirements
- R1: With opcode 0x00, function codes 0x20 and 0x21 return rs+rt and 0x22 and 0x23 return rs-rt, all modulo 2^32.
- R2: With opcode 0x00, function codes 0x24, 0x25, 0x26 and 0x27 return rs AND rt, rs OR rt, rs XOR rt and NOT(rs OR rt).
- R3: With opcode 0x00, function code 0x2A returns 1 when rs < rt as signed values, else 0. Function code 0x2B does the same as unsigned values. With rs=1 and rt=0xFFFFFFFF, 0x2A gives 0 and 0x2B gives 1.
- R4: With opcode 0x00, function codes 0x00, 0x02 and 0x03 shift the rt value by shamt_i: left logical, right logical, and right arithmetic with sign fill. 0xABCD1234 shifted right arithmetically by 4 gives 0xFABCD123.
- R5: Function codes 0x04, 0x06 and 0x07 perform the same three shifts on the rt value. The amount is the low 5 bits of the rs value, and shamt_i is ignored.
- R6: Signed overflow on function 0x20, function 0x22 or opcode 0x08 sets ovf_exc_o and clears wr_en_o, while result_o still shows the wrapped value. Function 0x21, function 0x23 and opcode 0x09 never set ovf_exc_o.
- R7: Opcodes 0x08 (add), 0x09 (add, no trap), 0x0A (signed less-than) and 0x0B (unsigned less-than) sign-extend the immediate and use it in place of rt. The rt value is ignored.
- R8: Opcodes 0x0C, 0x0D and 0x0E zero-extend the immediate and return rs AND, OR or XOR it.
- R9: Opcode 0x0F returns the immediate in bits 31:16 with bits 15:0 cleared, ignoring rs.
- R10: wr_idx_o is rd_idx_i when the opcode is 0x00 and rt_idx_i for every other opcode.
- R11: wr_en_o is 0 whenever wr_idx_o is 0. The all-zero instruction word writes nothing and returns the rt value.
- R12: Any opcode other than 0x00 and 0x08-0x0F raises illegal_o. So does any function code under opcode 0x00 outside {0x00,0x02,0x03,0x04,0x06,0x07,0x20-0x27,0x2A,0x2B}. An illegal encoding drives wr_en_o=0, ovf_exc_o=0 and result_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Primary operation code |
| funct_i | input | 6 | Function code for register-register forms |
| shamt_i | input | 5 | Constant shift amount field |
| imm_i | input | 16 | Immediate field |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| rd_idx_i | input | 5 | Destination index of register-register forms |
| rt_idx_i | input | 5 | Destination index of immediate forms |
| result_o | output | 32 | Computed result |
| wr_idx_o | output | 5 | Selected destination index |
| wr_en_o | output | 1 | Destination write enable |
| ovf_exc_o | output | 1 | Signed-overflow exception |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
The unit holds no state, so a wrong control field from the decoder shows at the ports in the same evaluation as the instruction that causes it. Typical symptoms are a wrong extension of the immediate, a shift amount taken from the wrong field, or a missing trap bit. Each shows as a mismatched result_o, or as wr_en_o and ovf_exc_o disagreeing with the encoding. The stimulus therefore pairs values whose outcome depends on the extension, the signedness or the source of the amount. Examples are a negative immediate against an unsigned compare and a shamt field that differs from the register amount. A single wrong decode then changes a visible output.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_ADDIU = 6'h09;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_SLTIU = 6'h0B;
  localparam logic [5:0] OPC_ANDI  = 6'h0C;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_XORI  = 6'h0E;
  localparam logic [5:0] OPC_LUI   = 6'h0F;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_SRAV = 6'h07;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLT, OP_SLTU, OP_SLL, OP_SRL, OP_SRA, OP_LUI
  } op_e;

  typedef struct packed {
    logic legal;
    op_e  op;
    logic use_imm;   // operand b from immediate
    logic imm_sext;  // sign- vs zero-extend
    logic amt_reg;   // shift amount from rs
    logic trap;      // overflow traps
    logic dst_rt;    // destination from rt field
  } ctrl_t;

endpackage

// File: rtl/alu_exec_decode.sv
module alu_exec_decode
  import alu_exec_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.op      = OP_ADD;
    ctrl_o.dst_rt  = (opcode_i != OPC_REG);
    ctrl_o.use_imm = (opcode_i != OPC_REG);
    case (opcode_i)
      OPC_REG: begin
        ctrl_o.legal = 1'b1;
        case (funct_i)
          FN_SLL:  ctrl_o.op = OP_SLL;
          FN_SRL:  ctrl_o.op = OP_SRL;
          FN_SRA:  ctrl_o.op = OP_SRA;
          FN_SLLV: begin ctrl_o.op = OP_SLL; ctrl_o.amt_reg = 1'b1; end
          FN_SRLV: begin ctrl_o.op = OP_SRL; ctrl_o.amt_reg = 1'b1; end
          FN_SRAV: begin ctrl_o.op = OP_SRA; ctrl_o.amt_reg = 1'b1; end
          FN_ADD:  begin ctrl_o.op = OP_ADD; ctrl_o.trap = 1'b1; end
          FN_ADDU: ctrl_o.op = OP_ADD;
          FN_SUB:  begin ctrl_o.op = OP_SUB; ctrl_o.trap = 1'b1; end
          FN_SUBU: ctrl_o.op = OP_SUB;
          FN_AND:  ctrl_o.op = OP_AND;
          FN_OR:   ctrl_o.op = OP_OR;
          FN_XOR:  ctrl_o.op = OP_XOR;
          FN_NOR:  ctrl_o.op = OP_NOR;
          FN_SLT:  ctrl_o.op = OP_SLT;
          FN_SLTU: ctrl_o.op = OP_SLTU;
          default: ctrl_o.legal = 1'b0;
        endcase
      end
      OPC_ADDI:  begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_ADD;  ctrl_o.imm_sext = 1'b1; ctrl_o.trap = 1'b1; end
      OPC_ADDIU: begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_ADD;  ctrl_o.imm_sext = 1'b1; end
      OPC_SLTI:  begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_SLT;  ctrl_o.imm_sext = 1'b1; end
      OPC_SLTIU: begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_SLTU; ctrl_o.imm_sext = 1'b1; end
      OPC_ANDI:  begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_AND; end
      OPC_ORI:   begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_OR;  end
      OPC_XORI:  begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_XOR; end
      OPC_LUI:   begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_LUI; end
      default:   ctrl_o.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_exec_addsub.sv
module alu_exec_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_o,
  output logic              lt_s_o,
  output logic              lt_u_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              carry;

  assign b_eff          = sub_i ? ~b_i : b_i;
  assign {carry, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};

  // same-sign inputs to the adder, different-sign output
  assign ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  assign lt_s_o = sum_o[MSB] ^ ovf_o;
  assign lt_u_o = ~carry;

endmodule

// File: rtl/alu_exec_shift.sv
module alu_exec_shift #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 5
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               left_i,
  input  logic               arith_i,
  output logic [DATA_W-1:0]  data_o
);

  logic [DATA_W-1:0] stg [SHAMT_W+1];
  logic              fill;

  assign fill   = arith_i & data_i[DATA_W-1];
  assign stg[0] = data_i;

  // log shifter, one stage per amount bit
  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = !amt_i[k] ? stg[k]
                    : left_i    ? {stg[k][DATA_W-1-S:0], {S{1'b0}}}
                    :             {{S{fill}}, stg[k][DATA_W-1:S]};
  end

  assign data_o = stg[SHAMT_W];

endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_exec_pkg::*;
#(
  parameter  int DATA_W  = 32,
  parameter  int IMM_W   = 16,
  parameter  int REG_W   = 5,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [5:0]         opcode_i,
  input  logic [5:0]         funct_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [DATA_W-1:0]  rs_val_i,
  input  logic [DATA_W-1:0]  rt_val_i,
  input  logic [REG_W-1:0]   rd_idx_i,
  input  logic [REG_W-1:0]   rt_idx_i,
  output logic [DATA_W-1:0]  result_o,
  output logic [REG_W-1:0]   wr_idx_o,
  output logic               wr_en_o,
  output logic               ovf_exc_o,
  output logic               illegal_o
);

  localparam int EXT_W = DATA_W - IMM_W;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] imm_ext, opb, sum, sh_res;
  logic              do_sub, ovf, lt_s, lt_u;
  logic [SHAMT_W-1:0] amt;

  alu_exec_decode i_decode (
    .opcode_i (opcode_i),
    .funct_i  (funct_i),
    .ctrl_o   (ctrl)
  );

  assign imm_ext = ctrl.imm_sext ? {{EXT_W{imm_i[IMM_W-1]}}, imm_i}
                                 : {{EXT_W{1'b0}}, imm_i};
  assign opb     = ctrl.use_imm ? imm_ext : rt_val_i;
  assign do_sub  = (ctrl.op == OP_SUB) || (ctrl.op == OP_SLT) || (ctrl.op == OP_SLTU);

  alu_exec_addsub #(.DATA_W(DATA_W)) i_addsub (
    .a_i    (rs_val_i),
    .b_i    (opb),
    .sub_i  (do_sub),
    .sum_o  (sum),
    .ovf_o  (ovf),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  assign amt = ctrl.amt_reg ? rs_val_i[SHAMT_W-1:0] : shamt_i;

  alu_exec_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) i_shift (
    .data_i  (rt_val_i),
    .amt_i   (amt),
    .left_i  (ctrl.op == OP_SLL),
    .arith_i (ctrl.op == OP_SRA),
    .data_o  (sh_res)
  );

  always_comb begin
    result_o = '0;
    if (ctrl.legal) begin
      case (ctrl.op)
        OP_ADD, OP_SUB: result_o = sum;
        OP_AND:  result_o = rs_val_i & opb;
        OP_OR:   result_o = rs_val_i | opb;
        OP_XOR:  result_o = rs_val_i ^ opb;
        OP_NOR:  result_o = ~(rs_val_i | opb);
        OP_SLT:  result_o = {{(DATA_W-1){1'b0}}, lt_s};
        OP_SLTU: result_o = {{(DATA_W-1){1'b0}}, lt_u};
        OP_SLL, OP_SRL, OP_SRA: result_o = sh_res;
        OP_LUI:  result_o = {imm_i, {EXT_W{1'b0}}};
        default: result_o = '0;
      endcase
    end
  end

  assign illegal_o = ~ctrl.legal;
  assign ovf_exc_o = ctrl.legal & ctrl.trap & ovf;
  assign wr_idx_o  = ctrl.dst_rt ? rt_idx_i : rd_idx_i;
  assign wr_en_o   = ctrl.legal & ~ovf_exc_o & (wr_idx_o != '0);

endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int REG_W  = 5
) (
  input logic [5:0]        opcode_i,
  input logic [5:0]        funct_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [DATA_W-1:0] result_o,
  input logic [REG_W-1:0]  wr_idx_o,
  input logic              wr_en_o,
  input logic              ovf_exc_o,
  input logic              illegal_o
);

  always_comb begin
    // R12
    if (illegal_o) illegal_quiet_chk: assert (!wr_en_o && !ovf_exc_o && result_o == '0);
    // R12
    if (opcode_i >= OPC_ADDI && opcode_i <= OPC_LUI) imm_legal_chk: assert (!illegal_o);
    // R11
    if (wr_idx_o == '0) zero_dst_chk: assert (!wr_en_o);
    // R6
    if (ovf_exc_o) ovf_no_write_chk: assert (!wr_en_o);
    // R6
    if (ovf_exc_o) ovf_trap_src_chk: assert (opcode_i == OPC_ADDI ||
        (opcode_i == OPC_REG && (funct_i == FN_ADD || funct_i == FN_SUB)));
    // R3
    if ((opcode_i == OPC_REG && (funct_i == FN_SLT || funct_i == FN_SLTU)) ||
        opcode_i == OPC_SLTI || opcode_i == OPC_SLTIU)
      slt_bool_chk: assert (result_o[DATA_W-1:1] == '0);
    // R9
    if (opcode_i == OPC_LUI)
      lui_shape_chk: assert (result_o == {imm_i, {(DATA_W-IMM_W){1'b0}}});
  end

endmodule

bind alu_exec alu_exec_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .REG_W(REG_W)) i_alu_exec_chk (
  .opcode_i  (opcode_i),
  .funct_i   (funct_i),
  .imm_i     (imm_i),
  .result_o  (result_o),
  .wr_idx_o  (wr_idx_o),
  .wr_en_o   (wr_en_o),
  .ovf_exc_o (ovf_exc_o),
  .illegal_o (illegal_o)
);

// File: tb/test_alu_exec.sv
`timescale 1ns/1ps
module test_alu_exec;

  typedef struct packed {
    logic [5:0]  opc;
    logic [5:0]  fn;
    logic [4:0]  sh;
    logic [15:0] imm;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        we;
    logic        ovf;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{6'h00, 6'h20, 5'd0, 16'h0, 32'd5, 32'd7, 32'd12, 1'b1, 1'b0, 1'b0, 4'd1},                        // R1 add
    '{6'h00, 6'h23, 5'd0, 16'h0, 32'd3, 32'd5, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b0, 4'd1},                  // R1 subu
    '{6'h00, 6'h21, 5'd0, 16'h0, 32'h7FFFFFFF, 32'd1, 32'h80000000, 1'b1, 1'b0, 1'b0, 4'd6},           // R6 addu no trap
    '{6'h00, 6'h20, 5'd0, 16'h0, 32'h7FFFFFFF, 32'd1, 32'h80000000, 1'b0, 1'b1, 1'b0, 4'd6},           // R6 add trap
    '{6'h00, 6'h22, 5'd0, 16'h0, 32'h80000000, 32'd1, 32'h7FFFFFFF, 1'b0, 1'b1, 1'b0, 4'd6},           // R6 sub trap
    '{6'h00, 6'h22, 5'd0, 16'h0, 32'd5, 32'd3, 32'd2, 1'b1, 1'b0, 1'b0, 4'd1},                         // R1 sub
    '{6'h00, 6'h24, 5'd0, 16'h0, 32'hABCD1234, 32'hFFFF0000, 32'hABCD0000, 1'b1, 1'b0, 1'b0, 4'd2},    // R2 and
    '{6'h00, 6'h25, 5'd0, 16'h0, 32'hABCD1234, 32'hFFFF0000, 32'hFFFF1234, 1'b1, 1'b0, 1'b0, 4'd2},    // R2 or
    '{6'h00, 6'h26, 5'd0, 16'h0, 32'hABCD1234, 32'hFFFF0000, 32'h54321234, 1'b1, 1'b0, 1'b0, 4'd2},    // R2 xor
    '{6'h00, 6'h27, 5'd0, 16'h0, 32'hABCD1234, 32'hFFFF0000, 32'h0000EDCB, 1'b1, 1'b0, 1'b0, 4'd2},    // R2 nor
    '{6'h00, 6'h2A, 5'd0, 16'h0, 32'd1, 32'hFFFFFFFF, 32'd0, 1'b1, 1'b0, 1'b0, 4'd3},                  // R3 slt
    '{6'h00, 6'h2B, 5'd0, 16'h0, 32'd1, 32'hFFFFFFFF, 32'd1, 1'b1, 1'b0, 1'b0, 4'd3},                  // R3 sltu
    '{6'h00, 6'h2A, 5'd0, 16'h0, 32'hFFFFFFFF, 32'd1, 32'd1, 1'b1, 1'b0, 1'b0, 4'd3},                  // R3 slt neg
    '{6'h00, 6'h00, 5'd8, 16'h0, 32'h0, 32'hABCD1234, 32'hCD123400, 1'b1, 1'b0, 1'b0, 4'd4},           // R4 sll
    '{6'h00, 6'h03, 5'd4, 16'h0, 32'h0, 32'hABCD1234, 32'hFABCD123, 1'b1, 1'b0, 1'b0, 4'd4},           // R4 sra
    '{6'h00, 6'h02, 5'd4, 16'h0, 32'h0, 32'hABCD1234, 32'h0ABCD123, 1'b1, 1'b0, 1'b0, 4'd4},           // R4 srl
    '{6'h00, 6'h07, 5'd31, 16'h0, 32'h24, 32'hABCD1234, 32'hFABCD123, 1'b1, 1'b0, 1'b0, 4'd5},         // R5 srav
    '{6'h00, 6'h06, 5'd31, 16'h0, 32'd16, 32'hABCD1234, 32'h0000ABCD, 1'b1, 1'b0, 1'b0, 4'd5},         // R5 srlv
    '{6'h00, 6'h04, 5'd0, 16'h0, 32'hFFFFFFE1, 32'h80000001, 32'h00000002, 1'b1, 1'b0, 1'b0, 4'd5},    // R5 sllv
    '{6'h08, 6'h3F, 5'd31, 16'hFFFF, 32'd10, 32'hDEADBEEF, 32'd9, 1'b1, 1'b0, 1'b0, 4'd7},             // R7 addi
    '{6'h08, 6'h00, 5'd0, 16'h0001, 32'h7FFFFFFF, 32'hDEADBEEF, 32'h80000000, 1'b0, 1'b1, 1'b0, 4'd6}, // R6 addi trap
    '{6'h09, 6'h00, 5'd0, 16'h0001, 32'h7FFFFFFF, 32'hDEADBEEF, 32'h80000000, 1'b1, 1'b0, 1'b0, 4'd6}, // R6 addiu
    '{6'h0A, 6'h00, 5'd0, 16'hFFFF, 32'hFFFFFFFE, 32'hDEADBEEF, 32'd1, 1'b1, 1'b0, 1'b0, 4'd7},        // R7 slti
    '{6'h0B, 6'h00, 5'd0, 16'hFFFF, 32'd5, 32'd0, 32'd1, 1'b1, 1'b0, 1'b0, 4'd7},                      // R7 sltiu
    '{6'h0C, 6'h00, 5'd0, 16'hF0F0, 32'hABCD1234, 32'hDEADBEEF, 32'h00001030, 1'b1, 1'b0, 1'b0, 4'd8}, // R8 andi
    '{6'h0D, 6'h00, 5'd0, 16'h8000, 32'hABCD1234, 32'hDEADBEEF, 32'hABCD9234, 1'b1, 1'b0, 1'b0, 4'd8}, // R8 ori
    '{6'h0E, 6'h00, 5'd0, 16'hFFFF, 32'h0, 32'hDEADBEEF, 32'h0000FFFF, 1'b1, 1'b0, 1'b0, 4'd8},        // R8 xori
    '{6'h0F, 6'h00, 5'd0, 16'hAC51, 32'h123, 32'hDEADBEEF, 32'hAC510000, 1'b1, 1'b0, 1'b0, 4'd9},      // R9 lui
    '{6'h03, 6'h20, 5'd0, 16'h1, 32'd1, 32'd1, 32'd0, 1'b0, 1'b0, 1'b1, 4'd12},                        // R12 opcode
    '{6'h00, 6'h01, 5'd0, 16'h0, 32'd1, 32'd1, 32'd0, 1'b0, 1'b0, 1'b1, 4'd12},                        // R12 funct
    '{6'h00, 6'h28, 5'd0, 16'h0, 32'h7FFFFFFF, 32'd1, 32'd0, 1'b0, 1'b0, 1'b1, 4'd12}                  // R12 funct
  };

  logic        clk = 1'b0;
  logic [5:0]  opcode, funct;
  logic [4:0]  shamt, rd_idx, rt_idx, wr_idx;
  logic [15:0] imm;
  logic [31:0] rs_val, rt_val, result;
  logic        wr_en, ovf_exc, illegal;
  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;

  always #10 clk = ~clk;

  alu_exec i_alu_exec (
    .opcode_i (opcode), .funct_i (funct), .shamt_i (shamt), .imm_i (imm),
    .rs_val_i (rs_val), .rt_val_i (rt_val), .rd_idx_i (rd_idx), .rt_idx_i (rt_idx),
    .result_o (result), .wr_idx_o (wr_idx), .wr_en_o (wr_en),
    .ovf_exc_o (ovf_exc), .illegal_o (illegal)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] o, input logic [5:0] f, input logic [4:0] s, input logic [15:0] i,
                       input logic [31:0] a, input logic [31:0] b, input logic [4:0] rd, input logic [4:0] rt);
    @(posedge clk);
    opcode = o; funct = f; shamt = s; imm = i; rs_val = a; rt_val = b; rd_idx = rd; rt_idx = rt;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=complete");
      finish_run();
    end
  end

  initial begin
    opcode = '0; funct = '0; shamt = '0; imm = '0; rs_val = '0; rt_val = '0; rd_idx = '0; rt_idx = '0;

    // R11: all-zero word is a no-write shift by zero
    drive(6'h00, 6'h00, 5'd0, 16'h0, 32'h0, 32'h13572468, 5'd0, 5'd0);
    check("R11", "zero-word we", {31'b0, wr_en}, 32'd0);
    check("R11", "zero-word result", result, 32'h13572468);
    check("R12", "zero-word illegal", {31'b0, illegal}, 32'd0);

    for (int n = 0; n < NV; n++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[n].req);
      drive(VECS[n].opc, VECS[n].fn, VECS[n].sh, VECS[n].imm, VECS[n].a, VECS[n].b, 5'd5, 5'd9);
      check(tag, $sformatf("vec%0d result", n), result, VECS[n].res);
      check(tag, $sformatf("vec%0d we", n), {31'b0, wr_en}, {31'b0, VECS[n].we});
      check(tag, $sformatf("vec%0d ovf", n), {31'b0, ovf_exc}, {31'b0, VECS[n].ovf});
      check(tag, $sformatf("vec%0d illegal", n), {31'b0, illegal}, {31'b0, VECS[n].ill});
      // R10: destination field chosen by opcode
      check("R10", $sformatf("vec%0d idx", n), {27'b0, wr_idx}, (VECS[n].opc == 6'h00) ? 32'd5 : 32'd9);
    end

    // R11: rd of zero on a register form
    drive(6'h00, 6'h21, 5'd0, 16'h0, 32'd1, 32'd1, 5'd0, 5'd7);
    check("R11", "rd0 we", {31'b0, wr_en}, 32'd0);
    check("R11", "rd0 result", result, 32'd2);
    check("R10", "rd0 idx", {27'b0, wr_idx}, 32'd0);

    // R11: rt of zero on an immediate form
    drive(6'h0D, 6'h00, 5'd0, 16'h00FF, 32'd0, 32'd0, 5'd3, 5'd0);
    check("R11", "rt0 we", {31'b0, wr_en}, 32'd0);
    check("R8", "rt0 result", result, 32'h000000FF);

    // R10: immediate form ignores rd field
    drive(6'h09, 6'h00, 5'd0, 16'h0002, 32'd3, 32'd0, 5'd0, 5'd31);
    check("R10", "imm idx", {27'b0, wr_idx}, 32'd31);
    check("R10", "imm we", {31'b0, wr_en}, 32'd1);
    check("R7", "addiu result", result, 32'd5);

    // R6: sub overflow the other direction; subu twin
    drive(6'h00, 6'h22, 5'd0, 16'h0, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd4, 5'd4);
    check("R6", "sub pos ovf", {31'b0, ovf_exc}, 32'd1);
    check("R6", "sub pos we", {31'b0, wr_en}, 32'd0);
    drive(6'h00, 6'h23, 5'd0, 16'h0, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd4, 5'd4);
    check("R6", "subu no ovf", {31'b0, ovf_exc}, 32'd0);
    check("R1", "subu wrap", result, 32'h80000000);

    // R4: shift by 31 keeps only sign; sra of positive fills zero
    drive(6'h00, 6'h03, 5'd31, 16'h0, 32'h0, 32'h80000000, 5'd2, 5'd2);
    check("R4", "sra31", result, 32'hFFFFFFFF);
    drive(6'h00, 6'h03, 5'd31, 16'h0, 32'h0, 32'h7FFFFFFF, 5'd2, 5'd2);
    check("R4", "sra31 pos", result, 32'h0);

    // R12: load-type opcode is not supported here
    drive(6'h23, 6'h20, 5'd0, 16'h4, 32'd8, 32'd8, 5'd6, 5'd6);
    check("R12", "load opc illegal", {31'b0, illegal}, 32'd1);
    check("R12", "load opc we", {31'b0, wr_en}, 32'd0);

    done = 1'b1;
    finish_run();
  end

endmodule